// File: doc/BRIEF.md
# Readback CRC Checksum Appender

This block sits on a serial readback path. Each accepted input bit is forwarded to the output one clock later. As the bits pass through, the block runs a 16-bit CRC over them, shifting serially. When the input marks a bit as the last one of a pass, the block follows that bit with a short checksum. The checksum is the upper 11 bits of the CRC register and goes out serially, one bit per clock. The output stream that results is the data followed directly by the checksum.

A downstream consumer can use the checksum to tell whether the readback contents changed between passes. To support this, the block keeps the checksum of the previous pass. It pulses a result flag, together with a "changed" bit, on the cycle that carries the final checksum bit. The CRC restarts from zero for every pass. Input bits that arrive while the checksum is being sent are dropped.

Top module: `rb_crc_appender`

## Requirements
- R1: A bit taken with `rd_valid`=1 outside checksum output appears on `tx_bit` one clock later, with `tx_valid`=1 and `tx_is_sum`=0.
- R2: The CRC uses generator 0x1021 (x^16+x^12+x^5+1) and shifts left. For each input bit d, the feedback is crc[15] XOR d. On feedback 1 the register becomes (crc<<1) XOR 0x1021; otherwise it becomes crc<<1.
- R3: A pass ends with the bit taken while `rd_end`=1. From the next clock on, exactly 11 checksum cycles follow back to back, each with `tx_valid`=1 and `tx_is_sum`=1.
- R4: The checksum bits are bits 15 down to 5 of the CRC after the last data bit, sent bit 15 first.
- R5: While checksum bits are being sent, `rd_valid`, `rd_bit` and `rd_end` have no effect: they change neither the checksum sequence nor the next pass's CRC.
- R6: `chk_valid` is high for exactly one cycle, the cycle of the 11th checksum bit. At that time `chk_changed` is 1 if and only if this 11-bit checksum differs from the one kept from the previous pass. The kept value is zero after reset.
- R7: While `rst` is high and on the cycle after it, `tx_valid`, `tx_is_sum` and `chk_valid` are 0.
- R8: The CRC register is zero at the start of every pass, so two identical passes produce identical checksums.
- R9: In a cycle that follows a clock with no accepted input and no checksum bit due, `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Input bit present |
| rd_bit | input | 1 | Readback data bit |
| rd_end | input | 1 | Marks the current bit as last of the pass |
| tx_valid | output | 1 | Output bit present |
| tx_bit | output | 1 | Output stream bit (data or checksum) |
| tx_is_sum | output | 1 | Output bit is a checksum bit |
| chk_valid | output | 1 | One-cycle compare result strobe |
| chk_changed | output | 1 | Checksum differs from the previous pass |

## Verification
On every cycle, assertions check several invariants: checksum cycles are always marked valid, the compare strobe lasts one cycle and only coincides with a checksum bit, the send phase always lasts eleven counts, a new pass never loads while a send is in progress, and the CRC register is zero after every pass. Other properties can only be shown by the bench scenarios. These are the actual checksum values for the generator, the most-significant-first order, the changed/unchanged verdict against the stored previous checksum, and the fact that stray input during the send phase leaves the next pass intact.

// File: rtl/rbcrc_pkg.sv
package rbcrc_pkg;

    localparam int          CRC_W    = 16;
    localparam int          SUM_W    = 11;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] cur,
        input logic             din
    );
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        crc_step = {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    typedef struct packed {
        logic valid;
        logic data;
        logic is_sum;
    } tx_beat_t;

endpackage

// File: rtl/rbcrc_core.sv
module rbcrc_core
    import rbcrc_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int SW = SUM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    input  logic          din,
    output logic [SW-1:0] sum_nxt
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_d;

    always_comb begin
        crc_d   = crc_step(crc_q, din);
        sum_nxt = crc_d[W-1 -: SW];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_q <= '0;
        else if (en)
            crc_q <= crc_d;
    end

    AST_CRC_ZERO_AFTER_PASS: assert property (@(posedge clk) disable iff (rst)
        clr |=> crc_q == '0); // R8
    AST_CRC_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(crc_q)); // R5

endmodule

// File: rtl/rbcrc_shifter.sv
module rbcrc_shifter
    import rbcrc_pkg::*;
#(
    parameter int SW = SUM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    output logic          busy,
    output logic          bit_out,
    output logic          done
);
    localparam int CNT_W = $clog2(SW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SW - 1);

    logic [SW-1:0]    sh_q;
    logic [CNT_W-1:0] cnt_q;

    assign bit_out = sh_q[SW-1];
    assign done    = busy && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            sh_q  <= load_val;
            cnt_q <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            sh_q  <= {sh_q[SW-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST)
                busy <= 1'b0;
        end
    end

    AST_SUM_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt_q) == LAST); // R3
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load); // R5

endmodule

// File: rtl/rbcrc_compare.sv
module rbcrc_compare
    import rbcrc_pkg::*;
#(
    parameter int SW = SUM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    input  logic          done,
    output logic          cmp_valid,
    output logic          cmp_diff
);
    logic [SW-1:0] cur_q;
    logic [SW-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            prev_q    <= '0;
            cmp_valid <= 1'b0;
            cmp_diff  <= 1'b0;
        end else begin
            cmp_valid <= done;
            if (load)
                cur_q <= load_val;
            if (done) begin
                prev_q   <= cur_q;
                cmp_diff <= (cur_q != prev_q);
            end
        end
    end

    AST_CMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> !cmp_valid); // R6

endmodule

// File: rtl/rb_crc_appender.sv
module rb_crc_appender
    import rbcrc_pkg::*;
#(
    parameter int W  = CRC_W,
    parameter int SW = SUM_W
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_valid,
    input  logic rd_bit,
    input  logic rd_end,
    output logic tx_valid,
    output logic tx_bit,
    output logic tx_is_sum,
    output logic chk_valid,
    output logic chk_changed
);
    logic          busy;
    logic          sum_bit;
    logic          sum_done;
    logic          accept;
    logic          pass_end;
    logic [SW-1:0] sum_nxt;
    tx_beat_t      beat_q;

    assign accept   = rd_valid && !busy;
    assign pass_end = accept && rd_end;

    rbcrc_core #(.W(W), .SW(SW)) u_core (
        .clk     (clk),
        .rst     (rst),
        .en      (accept),
        .clr     (pass_end),
        .din     (rd_bit),
        .sum_nxt (sum_nxt)
    );

    rbcrc_shifter #(.SW(SW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (pass_end),
        .load_val (sum_nxt),
        .busy     (busy),
        .bit_out  (sum_bit),
        .done     (sum_done)
    );

    rbcrc_compare #(.SW(SW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .load      (pass_end),
        .load_val  (sum_nxt),
        .done      (sum_done),
        .cmp_valid (chk_valid),
        .cmp_diff  (chk_changed)
    );

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else if (busy)
            beat_q <= '{valid: 1'b1, data: sum_bit, is_sum: 1'b1};
        else
            beat_q <= '{valid: rd_valid, data: rd_bit, is_sum: 1'b0};
    end

    assign tx_valid  = beat_q.valid;
    assign tx_bit    = beat_q.data;
    assign tx_is_sum = beat_q.is_sum;

    AST_SUM_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_is_sum |-> tx_valid); // R3
    AST_CMP_ON_SUM_BIT: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> tx_is_sum); // R6
    AST_SUM_FOLLOWS_END: assert property (@(posedge clk) disable iff (rst)
        pass_end |=> ##1 tx_is_sum); // R3

endmodule

// File: tb/tb_rb_crc_appender.sv
`timescale 1ns/1ps
module tb_rb_crc_appender;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_valid = 1'b0, rd_bit = 1'b0, rd_end = 1'b0;
    logic tx_valid, tx_bit, tx_is_sum, chk_valid, chk_changed;

    int total = 0;
    int bad   = 0;
    logic [10:0] prev_sum = '0;

    always #2.5 clk = ~clk;

    rb_crc_appender dut (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_bit(rd_bit), .rd_end(rd_end),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_is_sum(tx_is_sum),
        .chk_valid(chk_valid), .chk_changed(chk_changed)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_crc(input logic [63:0] d, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) begin
            logic top;
            top = r[15] ^ d[i];
            r = {r[14:0], 1'b0};
            if (top) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // one pass: n data bits from d (bit 0 first), optional idle gaps
    task automatic run_pass(input logic [63:0] d, input int n, input bit gaps);
        logic [15:0] crc;
        logic [10:0] sum;
        crc = model_crc(d, n);
        sum = crc[15:5];
        for (int k = 0; k < n; k++) begin
            rd_valid = 1'b1; rd_bit = d[k]; rd_end = (k == n - 1);
            @(negedge clk);
            chk(tx_valid, 1, "R1 data valid");
            chk(tx_bit, d[k], "R1 data bit");
            chk(tx_is_sum, 0, "R1 data tag");
            if (gaps && k != n - 1 && ($urandom % 3 == 0)) begin
                rd_valid = 1'b0; rd_bit = $urandom; rd_end = $urandom;
                @(negedge clk);
                chk(tx_valid, 0, "R9 idle gap");
            end
        end
        // stray input during send phase must be dropped (R5)
        rd_valid = $urandom; rd_bit = $urandom; rd_end = $urandom;
        for (int j = 0; j < 11; j++) begin
            @(negedge clk);
            chk(tx_valid, 1, "R3 sum valid");
            chk(tx_is_sum, 1, "R3 sum tag");
            chk(tx_bit, sum[10 - j], "R4 sum bit order");
            chk(chk_valid, (j == 10), "R6 strobe timing");
            if (j == 10)
                chk(chk_changed, (sum != prev_sum), "R6 changed flag");
            if (j < 10) begin
                rd_valid = $urandom; rd_bit = $urandom; rd_end = $urandom;
            end else begin
                rd_valid = 1'b0; rd_end = 1'b0;
            end
        end
        prev_sum = sum;
        @(negedge clk);
        chk(chk_valid, 0, "R6 single pulse");
        chk(tx_valid, 0, "R9 idle after sum");
        chk(tx_is_sum, 0, "R3 exactly eleven");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] rnd;
        void'($urandom(32'd1234));
        @(negedge clk);
        rd_valid = 1'b1; rd_bit = 1'b1; rd_end = 1'b1;
        @(negedge clk);
        chk(tx_valid, 0, "R7 reset valid");
        chk(tx_is_sum, 0, "R7 reset tag");
        chk(chk_valid, 0, "R7 reset strobe");
        rd_valid = 1'b0; rd_end = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(tx_valid, 0, "R7 after reset");

        // R2: single '1' gives 0x1021 -> sum 0x081, differs from zero
        run_pass(64'h1, 1, 0);
        // R8: same pass again, unchanged
        run_pass(64'h1, 1, 0);
        // single '0': CRC zero, changed vs previous
        run_pass(64'h0, 1, 0);
        run_pass(64'h0, 16, 0);
        run_pass(64'hFFFF_FFFF_FFFF_FFFF, 64, 0);
        for (int p = 0; p < 6; p++) begin
            rnd = {$urandom, $urandom};
            run_pass(rnd, 8 + ($urandom % 57), 1);
        end
        // R8 / R5: identical random pass twice, second must be unchanged
        rnd = {$urandom, $urandom};
        run_pass(rnd, 40, 1);
        run_pass(rnd, 40, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule